// File: doc/BRIEF.md
# Critical-Word-First Line Fill and Dirty-Word Writeback Engine

This block holds the tags, per-word valid bits, per-word dirty bits and data of a small direct-mapped data cache. It also sequences all memory traffic for that cache. A processor issues one word access at a time and holds its request until acknowledged. Because presence and modification are tracked per word, a line can be partly resident. Writes allocate a word without fetching the rest of its line. A read of an absent word starts a fill that asks memory for that word first and returns it to the processor the moment it arrives. The fill then requests the other words in wrap-around order, while the processor continues.

When a request names a line whose tag differs from the resident one, the engine first writes back only the modified words of the resident line, one per cycle. It then installs the new tag with every word absent. Memory is a word-wide port: posted writes, and reads answered a fixed number of cycles later. Only one read is in flight at a time.

The word address splits into offset (low OFF_W bits), line index (next IDX_W bits) and tag (the remaining upper bits).

Top module: `cwf_line_fill`

## Requirements
- R1: After reset every word is absent and clean; the first read of an address whose line tag differs from the reset tag of zero is acknowledged 3+LAT cycles after it is presented, where LAT is the memory read latency.
- R2: A read of a present word is acknowledged in the cycle it is presented, with the stored value.
- R3: On a read of an absent word in a resident line, the first memory read targets exactly the missed word, and the processor is acknowledged in the cycle that word returns (1+LAT cycles after presentation, from idle).
- R4: The remaining words of the line are requested at offsets missed+1, missed+2, ... modulo WORDS, one read at a time.
- R5: While a fill is running, a read of an already present word is acknowledged at once, and a read of a word not yet arrived is acknowledged in the cycle that word returns.
- R6: A write whose tag matches the resident line is acknowledged in the cycle presented and makes that word present and dirty; a write to a non-resident line installs the line without any memory read.
- R7: A read is served from memory when the tag matches but the word is absent, and a fill never replaces a word that is already present.
- R8: Before a different line is installed, each dirty word of the victim is written to memory, lowest offset first, one per cycle, and all these writes precede the first read for the new line.
- R9: Reading all WORDS words of a fresh line in order costs exactly WORDS memory reads; repeating those reads costs none.
- R10: Evicting a line with no dirty words issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack on a read |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = posted write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Read data returns this cycle |
| mem_rdata | input | DATA_W | Returned read data |

## Verification
A wrong valid bit shows within one access: either a present word is wrongly fetched, visible as a stall and an extra memory read, or an absent word is returned with stale data at once. A lost or stray dirty bit only shows at the next eviction of that line, as a missing or extra memory write, or as wrong memory contents. For this reason the bench forces evictions right after writes and counts writes exactly. Sequencing faults in the wrap order or in the critical-word response show as a memory read log in the wrong order, or as acknowledge latencies that differ from the cycle counts in the requirements.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_WB,
    ENG_FREQ,
    ENG_FWAIT
  } eng_state_e;
endpackage

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(LINES)-1:0]           a_idx,
  output logic [TAG_W-1:0]                   a_tag,
  output logic [WORDS-1:0]                   a_valid,
  output logic [WORDS-1:0][DATA_W-1:0]       a_data,
  input  logic [$clog2(LINES)-1:0]           b_idx,
  output logic [TAG_W-1:0]                   b_tag,
  output logic [WORDS-1:0]                   b_valid,
  output logic [WORDS-1:0]                   b_dirty,
  output logic [WORDS-1:0][DATA_W-1:0]       b_data,
  input  logic                               inst_en,
  input  logic [TAG_W-1:0]                   inst_tag,
  input  logic                               fill_en,
  input  logic [$clog2(WORDS)-1:0]           fill_off,
  input  logic [DATA_W-1:0]                  fill_data,
  input  logic                               clr_en,
  input  logic [$clog2(WORDS)-1:0]           clr_off,
  input  logic                               cw_en,
  input  logic [$clog2(LINES)-1:0]           cw_idx,
  input  logic [$clog2(WORDS)-1:0]           cw_off,
  input  logic [DATA_W-1:0]                  cw_data
);
  logic [TAG_W-1:0]             tag_q  [LINES];
  logic [WORDS-1:0]             val_q  [LINES];
  logic [WORDS-1:0]             dir_q  [LINES];
  logic [WORDS-1:0][DATA_W-1:0] data_q [LINES];

  logic fill_take;
  assign fill_take = fill_en && !val_q[b_idx][fill_off];

  assign a_tag   = tag_q[a_idx];
  assign a_valid = val_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_valid = val_q[b_idx];
  assign b_dirty = dir_q[b_idx];
  assign b_data  = data_q[b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        val_q[i] <= '0;
        dir_q[i] <= '0;
      end
    end else begin
      if (inst_en) begin
        tag_q[b_idx] <= inst_tag;
        val_q[b_idx] <= '0;
        dir_q[b_idx] <= '0;
      end
      if (fill_take) val_q[b_idx][fill_off] <= 1'b1;
      if (clr_en) dir_q[b_idx][clr_off] <= 1'b0;
      if (cw_en) begin
        val_q[cw_idx][cw_off] <= 1'b1;
        dir_q[cw_idx][cw_off] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_take) data_q[b_idx][fill_off] <= fill_data;
    if (cw_en) data_q[cw_idx][cw_off] <= cw_data;
  end

  // R6
  cw_sets_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |=> (val_q[$past(cw_idx)][$past(cw_off)] && dir_q[$past(cw_idx)][$past(cw_off)]));

  // R7
  fill_keeps_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && val_q[b_idx][fill_off] && !(cw_en && cw_idx == b_idx && cw_off == fill_off))
    |=> (data_q[$past(b_idx)][$past(fill_off)] == $past(data_q[b_idx][fill_off])));
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  evict_go,
  input  logic                                  fill_go,
  input  logic [$clog2(LINES)-1:0]              go_idx,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] go_tag,
  input  logic [$clog2(WORDS)-1:0]              go_off,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] b_tag,
  input  logic [WORDS-1:0]                      b_valid,
  input  logic [WORDS-1:0]                      b_dirty,
  input  logic [WORDS-1:0][DATA_W-1:0]          b_data,
  input  logic                                  mem_rvalid,
  output logic                                  mem_req,
  output logic                                  mem_we,
  output logic [ADDR_W-1:0]                     mem_addr,
  output logic [DATA_W-1:0]                     mem_wdata,
  output logic [$clog2(LINES)-1:0]              eng_idx,
  output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] eng_tag,
  output logic                                  inst_en,
  output logic                                  fill_en,
  output logic [$clog2(WORDS)-1:0]              fill_off,
  output logic                                  clr_en,
  output logic [$clog2(WORDS)-1:0]              clr_off,
  output logic                                  eng_idle,
  output logic                                  eng_arrive
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_K = OFF_W'(WORDS - 1);

  function automatic logic [OFF_W-1:0] wrap_off(logic [OFF_W-1:0] crit, logic [OFF_W-1:0] k);
    return crit + k;
  endfunction

  function automatic logic [OFF_W-1:0] first_dirty(logic [WORDS-1:0] d);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int i = WORDS - 1; i >= 0; i--) if (d[i]) r = OFF_W'(i);
    return r;
  endfunction

  eng_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [OFF_W-1:0] crit_q, k_q, cur_off, fd;
  logic             any_dirty;

  assign cur_off    = wrap_off(crit_q, k_q);
  assign fd         = first_dirty(b_dirty);
  assign any_dirty  = |b_dirty;
  assign eng_idx    = idx_q;
  assign eng_tag    = tag_q;
  assign fill_off   = cur_off;
  assign clr_off    = fd;
  assign eng_idle   = (st_q == ENG_IDLE);
  assign eng_arrive = (st_q == ENG_FWAIT) && mem_rvalid;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    inst_en   = 1'b0;
    fill_en   = 1'b0;
    clr_en    = 1'b0;
    case (st_q)
      ENG_WB: begin
        if (any_dirty) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {b_tag, idx_q, fd};
          mem_wdata = b_data[fd];
          clr_en    = 1'b1;
        end else begin
          inst_en = 1'b1;
        end
      end
      ENG_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = {tag_q, idx_q, cur_off};
      end
      ENG_FWAIT: fill_en = mem_rvalid;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      idx_q  <= '0;
      tag_q  <= '0;
      crit_q <= '0;
      k_q    <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (evict_go) begin
            idx_q <= go_idx;
            tag_q <= go_tag;
            st_q  <= ENG_WB;
          end else if (fill_go) begin
            idx_q  <= go_idx;
            tag_q  <= go_tag;
            crit_q <= go_off;
            k_q    <= '0;
            st_q   <= ENG_FREQ;
          end
        end
        ENG_WB:   if (!any_dirty) st_q <= ENG_IDLE;
        ENG_FREQ: st_q <= ENG_FWAIT;
        ENG_FWAIT: begin
          if (mem_rvalid) begin
            if (k_q == LAST_K) st_q <= ENG_IDLE;
            else begin
              k_q  <= k_q + 1'b1;
              st_q <= ENG_FREQ;
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  // R8
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> b_dirty[mem_addr[OFF_W-1:0]]);

  // R8
  install_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |=> (b_valid == '0 && b_dirty == '0));

  // R3
  resp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (st_q == ENG_FWAIT));
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [OFF_W-1:0] addr_off(logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] addr_tag(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [OFF_W-1:0]             c_off;
  logic [IDX_W-1:0]             c_idx;
  logic [TAG_W-1:0]             c_tag;
  logic [TAG_W-1:0]             a_tag, b_tag, eng_tag;
  logic [WORDS-1:0]             a_valid, b_valid, b_dirty;
  logic [WORDS-1:0][DATA_W-1:0] a_data, b_data;
  logic [IDX_W-1:0]             eng_idx;
  logic [OFF_W-1:0]             fill_off, clr_off;
  logic inst_en, fill_en, clr_en, eng_idle, eng_arrive;
  logic tag_hit, word_here, arr_match, rd_ack, wr_ack, evict_go, fill_go;

  assign c_off = addr_off(cpu_addr);
  assign c_idx = addr_idx(cpu_addr);
  assign c_tag = addr_tag(cpu_addr);

  // Named lookup events
  assign tag_hit   = (a_tag == c_tag);
  assign word_here = a_valid[c_off];
  assign arr_match = eng_arrive && (c_idx == eng_idx) && (c_tag == eng_tag)
                   && (c_off == fill_off) && !word_here;
  assign rd_ack    = cpu_req && !cpu_we && ((tag_hit && word_here) || arr_match);
  assign wr_ack    = cpu_req && cpu_we && tag_hit;
  assign evict_go  = cpu_req && eng_idle && !tag_hit;
  assign fill_go   = cpu_req && eng_idle && !cpu_we && tag_hit && !word_here;

  assign cpu_ack   = rd_ack || wr_ack;
  assign cpu_rdata = arr_match ? mem_rdata : a_data[c_off];

  cwf_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_tag(a_tag), .a_valid(a_valid), .a_data(a_data),
    .b_idx(eng_idx), .b_tag(b_tag), .b_valid(b_valid), .b_dirty(b_dirty), .b_data(b_data),
    .inst_en(inst_en), .inst_tag(eng_tag),
    .fill_en(fill_en), .fill_off(fill_off), .fill_data(mem_rdata),
    .clr_en(clr_en), .clr_off(clr_off),
    .cw_en(wr_ack), .cw_idx(c_idx), .cw_off(c_off), .cw_data(cpu_wdata)
  );

  cwf_fill_seq #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .evict_go(evict_go), .fill_go(fill_go),
    .go_idx(c_idx), .go_tag(c_tag), .go_off(c_off),
    .b_tag(b_tag), .b_valid(b_valid), .b_dirty(b_dirty), .b_data(b_data),
    .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .eng_idx(eng_idx), .eng_tag(eng_tag),
    .inst_en(inst_en), .fill_en(fill_en), .fill_off(fill_off),
    .clr_en(clr_en), .clr_off(clr_off),
    .eng_idle(eng_idle), .eng_arrive(eng_arrive)
  );

  // R5
  read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_we) |-> (a_valid[c_off] || mem_rvalid));

  // R2
  hit_no_mem_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && tag_hit && word_here && eng_idle) |=> !(mem_req && !mem_we));
endmodule

// File: tb/cwf_line_fill_bench.sv
module cwf_line_fill_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LAT    = 3;
  localparam int MSIZE  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ack;
  logic [DATA_W-1:0] cpu_rdata;
  logic mem_req, mem_we, mem_rvalid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  cwf_line_fill u_cwf_line_fill (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [DATA_W-1:0] seed_val(int a);
    return DATA_W'((a * 16'h0101) ^ 16'h5a00);
  endfunction

  // Memory model: posted writes, reads answered LAT cycles later
  logic [DATA_W-1:0] mem_arr [MSIZE];
  logic [DATA_W-1:0] ref_mem [MSIZE];
  logic [LAT-1:0] pv;
  logic [ADDR_W-1:0] pa [LAT];
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W:0] ev_q [$];

  initial for (int i = 0; i < MSIZE; i++) begin
    mem_arr[i] = seed_val(i);
    ref_mem[i] = seed_val(i);
  end

  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = mem_arr[pa[LAT-1]];

  always @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else begin
      pv[0] <= mem_req && !mem_we;
      pa[0] <= mem_addr;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
      end
      if (mem_req && mem_we) begin
        mem_arr[mem_addr] <= mem_wdata;
        wr_cnt++;
        ev_q.push_back({1'b1, mem_addr});
      end
      if (mem_req && !mem_we) begin
        rd_cnt++;
        ev_q.push_back({1'b0, mem_addr});
      end
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Scoreboard
  logic [DATA_W-1:0] exp_q [$];
  string             rq_q  [$];

  always @(negedge clk) begin
    #2;
    if (rst_n && cpu_req && cpu_ack && !cpu_we) begin
      if (exp_q.size() == 0) check(1'b0, "read without expectation", 0, 1);
      else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string r = rq_q.pop_front();
        check(cpu_rdata == e, r, cpu_rdata, e);
      end
    end
  end

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input int exp_wait, input string rq);
    int w;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (!we) begin
      exp_q.push_back(ref_mem[a]);
      rq_q.push_back(rq);
    end else ref_mem[a] = d;
    w = 0;
    #1;
    while (!cpu_ack) begin
      @(negedge clk); #1;
      w++;
    end
    if (exp_wait >= 0) check(w == exp_wait, {rq, " ack latency"}, w, exp_wait);
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic check_ev(input int pos, input bit we, input logic [ADDR_W-1:0] a, input string rq);
    if (pos >= ev_q.size()) check(1'b0, {rq, " missing memory event"}, pos, ev_q.size());
    else check(ev_q[pos] == {we, a}, rq, ev_q[pos], {we, a});
  endtask

  initial begin
    int base, rc, wc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    // R1: reset state, nothing moved to memory
    check(rd_cnt == 0 && wr_cnt == 0, "R1 idle memory after reset", rd_cnt + wr_cnt, 0);
    // R1 R3: miss on fresh line, critical word first
    access(0, 8'h12, 0, 3 + LAT, "R1 first miss");
    check_ev(0, 0, 8'h12, "R3 critical word requested first");
    // R5: unfilled word stalls until it arrives
    access(0, 8'h13, 0, LAT, "R5 read of word in flight");
    // R5: present word during fill served at once
    access(0, 8'h12, 0, 0, "R5 present word during fill");
    access(0, 8'h11, 0, 6, "R5 last word of wrap");
    repeat (4) @(posedge clk);
    // R4: wrap order
    check_ev(1, 0, 8'h13, "R4 wrap order second");
    check_ev(2, 0, 8'h10, "R4 wrap order third");
    check_ev(3, 0, 8'h11, "R4 wrap order fourth");
    // R2 R9: all hits, no more memory reads
    for (int i = 0; i < 4; i++) access(0, 8'h10 + 8'(i), 0, 0, "R2 hit");
    check(rd_cnt == 4, "R9 one line costs WORDS reads", rd_cnt, 4);
    // R6: write hits
    access(1, 8'h11, 16'hbeef, 0, "R6 write hit");
    access(1, 8'h13, 16'hc0de, 0, "R6 write hit");
    access(0, 8'h11, 0, 0, "R6 read after write");
    // R6 R10: write to a non-resident clean line, no memory traffic
    rc = rd_cnt; wc = wr_cnt;
    access(1, 8'h25, 16'h1234, 2, "R6 write allocate");
    check(rd_cnt == rc, "R6 no fetch on write allocate", rd_cnt, rc);
    check(wr_cnt == wc, "R10 clean eviction writes nothing", wr_cnt, wc);
    // R7: tag matches, word absent
    base = ev_q.size();
    access(0, 8'h24, 0, 1 + LAT, "R7 absent word in resident line");
    check_ev(base, 0, 8'h24, "R7 memory read for absent word");
    access(0, 8'h25, 0, 0, "R7 present written word during fill");
    repeat (20) @(posedge clk);
    access(0, 8'h25, 0, 0, "R7 fill kept written word");
    access(0, 8'h27, 0, 0, "R7 filled word");
    // R8: dirty-only writeback before the new line's read
    base = ev_q.size(); wc = wr_cnt;
    access(0, 8'h32, 0, 3 + 2 + LAT, "R8 miss with two dirty words");
    check(wr_cnt - wc == 2, "R8 only dirty words written", wr_cnt - wc, 2);
    check_ev(base, 1, 8'h11, "R8 lowest dirty first");
    check_ev(base + 1, 1, 8'h13, "R8 next dirty");
    check_ev(base + 2, 0, 8'h32, "R8 read after writeback");
    check(mem_arr[8'h11] == 16'hbeef, "R8 memory holds written word", mem_arr[8'h11], 16'hbeef);
    check(mem_arr[8'h13] == 16'hc0de, "R8 memory holds written word", mem_arr[8'h13], 16'hc0de);
    repeat (20) @(posedge clk);
    // R10: evict clean line
    wc = wr_cnt;
    access(0, 8'h40, 0, 3 + LAT, "R10 clean line replacement");
    check(wr_cnt == wc, "R10 no write for clean victim", wr_cnt, wc);
    repeat (20) @(posedge clk);
    // R8: refetch of evicted words returns written data
    access(0, 8'h11, 0, -1, "R8 refetch written word");
    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule